// File: doc/BRIEF.md
# Transmit Descriptor Status Register Bank

This block keeps the status words for a small ring of transmit descriptors. Each descriptor has one 32-bit word that two parties share. The host writes a byte count into the word to hand the descriptor to hardware. The transmit DMA engine later reports how that transmission ended, and the result lands in the same word. A new byte count from the host wipes the previous outcome and takes ownership away from hardware. A completion from the DMA side fills in the outcome and gives ownership back to the host.

Host accesses are accepted only as full 32-bit writes. Every outcome report also produces a one-cycle interrupt pulse, either for a good transmission or for a failed one. A round-robin pointer shows which descriptor the DMA side is expected to serve next. Host reads are registered and return data one cycle after the address is presented.

Top module: `txdesc_status_bank`

## Requirements
- R1: After reset every descriptor word reads byte count 0, ownership bit (bit 13) set to 1, and all status bits and the collision count cleared.
- R2: The four descriptor words sit at byte addresses 0x10, 0x14, 0x18 and 0x1C. `host_rd_data` shows the word at `host_rd_addr` one clock later. Any other address, misaligned ones included, reads as 0 and ignores writes.
- R3: A write with `host_wr_be` equal to 4'hF loads bits 12:0 of `host_wr_data` as the byte count and clears the ownership bit. A write with any other byte-enable pattern changes nothing.
- R4: An accepted write clears the underrun (bit 14), transmit-good (bit 15), abort (bit 16), late-collision (bit 17), heartbeat-lost (bit 18) and carrier-lost (bit 19) flags and the collision count (bits 23:20). Data bits 31:13 of the write have no effect, and bits 31:24 always read 0.
- R5: A `dma_done` pulse for index `dma_idx` sets that word's ownership bit and latches the reported flags and collision count. The byte count is left as it was.
- R6: A completion that reports underrun stores underrun=1 and transmit-good=0, even when `dma_ok` is also high. A reported abort also forces transmit-good to 0.
- R7: The 5-bit `dma_coll` input is stored in the 4-bit collision count field and saturates at 15.
- R8: One clock after `dma_done`, exactly one interrupt pulses. `irq_tx_ok` pulses when the completion is good with no underrun and no abort; otherwise `irq_tx_err` pulses. Neither pulses without a completion.
- R9: `next_desc` resets to 0 and steps through 0, 1, 2, 3, 0 on each `dma_done`.
- R10: When a host write and a completion hit the same descriptor in the same cycle, the write wins in that word, while the interrupt and the pointer still respond to the completion. When they hit different descriptors, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_addr | input | 8 | Host write byte address |
| host_wr_be | input | 4 | Host write byte enables |
| host_wr_data | input | 32 | Host write data |
| host_rd_addr | input | 8 | Host read byte address |
| host_rd_data | output | 32 | Registered read data |
| dma_done | input | 1 | Completion report strobe |
| dma_idx | input | 2 | Descriptor being reported |
| dma_ok | input | 1 | Transmission good |
| dma_underrun | input | 1 | FIFO underrun occurred |
| dma_abort | input | 1 | Transmission aborted |
| dma_owc | input | 1 | Late (out-of-window) collision seen |
| dma_hbt_lost | input | 1 | Heartbeat missing |
| dma_crs_lost | input | 1 | Carrier lost during send |
| dma_coll | input | 5 | Raw collision count |
| next_desc | output | 2 | Round-robin next descriptor pointer |
| irq_tx_ok | output | 1 | Good-completion interrupt pulse |
| irq_tx_err | output | 1 | Failed-completion interrupt pulse |

## Verification
A host write of a new byte count and a DMA completion can arrive in the same clock. They can target the same descriptor or different ones. The bench drives both strobes on the same edge, once with equal indices and once with different indices. It then reads the affected words back through the host port. In the same-index case it expects the fresh byte count with ownership cleared and no stale status, yet it still expects the interrupt pulse and the pointer step. In the split case it expects each word to carry its own update.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int CNT_W   = 13;
  localparam int NCC_W   = 4;
  localparam int WORD_W  = 32;
  localparam int POS_OWN = 13;
  localparam int POS_TUN = 14;
  localparam int POS_TOK = 15;
  localparam int POS_ABT = 16;
  localparam int POS_OWC = 17;
  localparam int POS_HBT = 18;
  localparam int POS_CRS = 19;
  localparam int POS_NCC = 20;
  localparam int NCC_MAX = (1 << NCC_W) - 1;

  typedef struct packed {
    logic             ok;
    logic             underrun;
    logic             abort;
    logic             owc;
    logic             hbt;
    logic             crs;
    logic [NCC_W-1:0] ncc;
  } txd_cmp_t;
endpackage

// File: rtl/txd_slot.sv
module txd_slot
  import txd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [CNT_W-1:0]  wr_count,
  input  logic              cmp_hit,
  input  txd_cmp_t          cmp,
  output logic [WORD_W-1:0] word
);
  logic [CNT_W-1:0] count;
  logic             own, tun, tok, abt, owc, hbt, crs;
  logic [NCC_W-1:0] ncc;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      own   <= 1'b1;
      {tun, tok, abt, owc, hbt, crs} <= '0;
      ncc   <= '0;
    end else if (wr_hit) begin
      count <= wr_count;
      own   <= 1'b0;
      {tun, tok, abt, owc, hbt, crs} <= '0;
      ncc   <= '0;
    end else if (cmp_hit) begin
      own <= 1'b1;
      tun <= cmp.underrun;
      tok <= cmp.ok & ~cmp.underrun & ~cmp.abort;
      abt <= cmp.abort;
      owc <= cmp.owc;
      hbt <= cmp.hbt;
      crs <= cmp.crs;
      ncc <= cmp.ncc;
    end
  end

  always_comb begin
    word = '0;
    word[CNT_W-1:0]           = count;
    word[POS_OWN]             = own;
    word[POS_TUN]             = tun;
    word[POS_TOK]             = tok;
    word[POS_ABT]             = abt;
    word[POS_OWC]             = owc;
    word[POS_HBT]             = hbt;
    word[POS_CRS]             = crs;
    word[POS_NCC+NCC_W-1:POS_NCC] = ncc;
  end

  assert_wr_loads_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> word[CNT_W-1:0] == $past(wr_count));
  assert_wr_clears_R4: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> word[WORD_W-1:CNT_W] == '0);
  assert_done_owns_R5: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit && !wr_hit) |=> (word[POS_OWN] && $stable(word[CNT_W-1:0])));
  assert_tun_no_tok_R6: assert property (@(posedge clk) disable iff (rst)
    (cmp_hit && !wr_hit && cmp.underrun) |=> (word[POS_TUN] && !word[POS_TOK]));
endmodule

// File: rtl/txd_rr_ptr.sv
module txd_rr_ptr #(
  parameter int N     = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (step) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (step && ptr == LAST) |=> ptr == '0);
  assert_ptr_step_R9: assert property (@(posedge clk) disable iff (rst)
    (step && ptr != LAST) |=> ptr == $past(ptr) + 1'b1);
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(ptr));
endmodule

// File: rtl/txd_irq.sv
module txd_irq
  import txd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     done,
  input  txd_cmp_t cmp,
  output logic     irq_ok,
  output logic     irq_err
);
  logic good;
  assign good = cmp.ok & ~cmp.underrun & ~cmp.abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ok  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_ok  <= done & good;
      irq_err <= done & ~good;
    end
  end

  assert_irq_excl_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({irq_ok, irq_err}));
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_ok || irq_err) |-> $past(done));
  assert_irq_every_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> (irq_ok || irq_err));
endmodule

// File: rtl/txdesc_status_bank.sv
module txdesc_status_bank
  import txd_pkg::*;
#(
  parameter int NUM_DESC  = 4,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h10,
  localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr_en,
  input  logic [ADDR_W-1:0] host_wr_addr,
  input  logic [3:0]        host_wr_be,
  input  logic [WORD_W-1:0] host_wr_data,
  input  logic [ADDR_W-1:0] host_rd_addr,
  output logic [WORD_W-1:0] host_rd_data,
  input  logic              dma_done,
  input  logic [IDX_W-1:0]  dma_idx,
  input  logic              dma_ok,
  input  logic              dma_underrun,
  input  logic              dma_abort,
  input  logic              dma_owc,
  input  logic              dma_hbt_lost,
  input  logic              dma_crs_lost,
  input  logic [NCC_W:0]    dma_coll,
  output logic [IDX_W-1:0]  next_desc,
  output logic              irq_tx_ok,
  output logic              irq_tx_err
);
  localparam int LO = BASE_ADDR;
  localparam int HI = BASE_ADDR + 4 * NUM_DESC;

  logic                           wr_in, rd_in, wr_full;
  logic [IDX_W-1:0]               wr_idx, rd_idx;
  logic [NUM_DESC-1:0][WORD_W-1:0] words;
  txd_cmp_t                       cmp;
  logic                           unused_hi;

  assign unused_hi = ^host_wr_data[WORD_W-1:CNT_W];

  assign wr_full = (host_wr_be == 4'hF);
  assign wr_in   = (int'(host_wr_addr) >= LO) && (int'(host_wr_addr) < HI) &&
                   (host_wr_addr[1:0] == 2'b00);
  assign rd_in   = (int'(host_rd_addr) >= LO) && (int'(host_rd_addr) < HI) &&
                   (host_rd_addr[1:0] == 2'b00);
  assign wr_idx  = IDX_W'((int'(host_wr_addr) - LO) >> 2);
  assign rd_idx  = IDX_W'((int'(host_rd_addr) - LO) >> 2);

  always_comb begin
    cmp.ok       = dma_ok;
    cmp.underrun = dma_underrun;
    cmp.abort    = dma_abort;
    cmp.owc      = dma_owc;
    cmp.hbt      = dma_hbt_lost;
    cmp.crs      = dma_crs_lost;
    cmp.ncc      = (int'(dma_coll) > NCC_MAX) ? NCC_W'(NCC_MAX) : dma_coll[NCC_W-1:0];
  end

  for (genvar i = 0; i < NUM_DESC; i++) begin : g_slot
    txd_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .wr_hit   (host_wr_en && wr_full && wr_in && (wr_idx == IDX_W'(i))),
      .wr_count (host_wr_data[CNT_W-1:0]),
      .cmp_hit  (dma_done && (dma_idx == IDX_W'(i))),
      .cmp      (cmp),
      .word     (words[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)        host_rd_data <= '0;
    else if (rd_in) host_rd_data <= words[rd_idx];
    else            host_rd_data <= '0;
  end

  txd_rr_ptr #(.N(NUM_DESC)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .step (dma_done),
    .ptr  (next_desc)
  );

  txd_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .done    (dma_done),
    .cmp     (cmp),
    .irq_ok  (irq_tx_ok),
    .irq_err (irq_tx_err)
  );

  assert_partial_ignored_R3: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && !wr_full && !dma_done) |=> $stable(words));
  assert_outside_ignored_R2: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && !wr_in && !dma_done) |=> $stable(words));
  assert_ncc_sat_R7: assert property (@(posedge clk) disable iff (rst)
    (dma_done && int'(dma_coll) > NCC_MAX) |-> cmp.ncc == NCC_W'(NCC_MAX));
endmodule

// File: tb/txdesc_status_bank_tb_top.sv
module txdesc_status_bank_tb_top;
  logic        clk = 0;
  logic        rst;
  logic        host_wr_en;
  logic [7:0]  host_wr_addr;
  logic [3:0]  host_wr_be;
  logic [31:0] host_wr_data;
  logic [7:0]  host_rd_addr;
  logic [31:0] host_rd_data;
  logic        dma_done;
  logic [1:0]  dma_idx;
  logic        dma_ok, dma_underrun, dma_abort, dma_owc, dma_hbt_lost, dma_crs_lost;
  logic [4:0]  dma_coll;
  logic [1:0]  next_desc;
  logic        irq_tx_ok, irq_tx_err;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  txdesc_status_bank dut_i (.*);

  task automatic chk(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int cnt, input bit own, input bit tun, input bit tok,
                                     input bit abt, input bit owc, input bit hbt, input bit crs,
                                     input int ncc);
    return {8'h00, 4'(ncc), crs, hbt, owc, abt, tok, tun, own, 13'(cnt)};
  endfunction

  // scoreboard monitor: compares registered read data
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(host_rd_data === e, t, host_rd_data, e);
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    host_rd_addr = a;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    host_wr_en = 1; host_wr_addr = a; host_wr_be = be; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 0;
  endtask

  task automatic set_dma(input int idx, input bit ok, input bit un, input bit ab, input bit ow,
                         input bit hb, input bit cr, input int coll);
    dma_done = 1; dma_idx = 2'(idx); dma_ok = ok; dma_underrun = un; dma_abort = ab;
    dma_owc = ow; dma_hbt_lost = hb; dma_crs_lost = cr; dma_coll = 5'(coll);
  endtask

  task automatic irq_chk(input bit eok, input bit eerr, input string tag);
    chk(irq_tx_ok === eok && irq_tx_err === eerr, tag, {30'b0, irq_tx_ok, irq_tx_err}, {30'b0, eok, eerr});
    dma_done = 0;
    @(negedge clk);
    chk(irq_tx_ok === 0 && irq_tx_err === 0, {tag, " quiet"}, {30'b0, irq_tx_ok, irq_tx_err}, 32'h0);
  endtask

  task automatic dma(input int idx, input bit ok, input bit un, input bit ab, input bit ow,
                     input bit hb, input bit cr, input int coll, input bit eok, input bit eerr,
                     input string tag);
    @(negedge clk);
    set_dma(idx, ok, un, ab, ow, hb, cr, coll);
    @(negedge clk);
    irq_chk(eok, eerr, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1; host_wr_en = 0; host_wr_addr = 0; host_wr_be = 0; host_wr_data = 0;
    host_rd_addr = 0; dma_done = 0; dma_idx = 0; dma_ok = 0; dma_underrun = 0;
    dma_abort = 0; dma_owc = 0; dma_hbt_lost = 0; dma_crs_lost = 0; dma_coll = 0;
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1 reset state
    for (int i = 0; i < 4; i++) rd(8'(8'h10 + 4*i), mk(0,1,0,0,0,0,0,0,0), "R1 reset word");
    @(negedge clk);
    chk(next_desc === 0 && irq_tx_ok === 0 && irq_tx_err === 0, "R1/R9 reset outputs",
        {28'b0, next_desc, irq_tx_ok, irq_tx_err}, 32'h0);

    // R3/R4 full write, upper data bits ignored
    wr(8'h10, 4'hF, 32'hFFFF_E123);
    rd(8'h10, mk('h123,0,0,0,0,0,0,0,0), "R3 R4 full write loads count");
    // R3 partial write ignored
    wr(8'h14, 4'h3, 32'h0000_0005);
    rd(8'h14, mk(0,1,0,0,0,0,0,0,0), "R3 partial write ignored");
    // R2 out-of-range and misaligned writes ignored, reads 0
    wr(8'h20, 4'hF, 32'h0000_0777);
    wr(8'h16, 4'hF, 32'h0000_0666);
    rd(8'h20, 32'h0, "R2 outside reads zero");
    rd(8'h14, mk(0,1,0,0,0,0,0,0,0), "R2 misaligned write ignored");
    rd(8'h1C, mk(0,1,0,0,0,0,0,0,0), "R2 outside write ignored");

    // R5/R8 good completion
    wr(8'h14, 4'hF, 32'h0000_0040);
    dma(1, 1,0,0,0,0,0, 3, 1, 0, "R8 good irq");
    rd(8'h14, mk('h40,1,0,1,0,0,0,0,3), "R5 completion latched");
    chk(next_desc === 1, "R9 step", 32'(next_desc), 32'd1);

    // R6 underrun with ok high
    dma(0, 1,1,0,0,0,0, 0, 0, 1, "R6 R8 underrun irq err");
    rd(8'h10, mk('h123,1,1,0,0,0,0,0,0), "R6 underrun no tok");

    // R7 saturation, all error flags
    wr(8'h18, 4'hF, 32'h0000_07FF);
    dma(2, 0,0,1,1,1,1, 20, 0, 1, "R8 abort irq err");
    rd(8'h18, mk('h7FF,1,0,0,1,1,1,1,15), "R7 collision saturates");

    dma(3, 1,0,0,0,0,0, 15, 1, 0, "R8 good irq d3");
    rd(8'h1C, mk(0,1,0,1,0,0,0,0,15), "R7 count 15 exact");
    chk(next_desc === 0, "R9 wrap", 32'(next_desc), 32'd0);

    // R4 rewrite clears prior status
    wr(8'h18, 4'hF, 32'h0000_0010);
    rd(8'h18, mk('h10,0,0,0,0,0,0,0,0), "R4 rewrite clears status");

    // R10 same descriptor, same cycle
    @(negedge clk);
    host_wr_en = 1; host_wr_addr = 8'h1C; host_wr_be = 4'hF; host_wr_data = 32'h55;
    set_dma(3, 1,0,0,0,0,0, 2);
    @(negedge clk);
    host_wr_en = 0;
    irq_chk(1, 0, "R10 irq on collision");
    rd(8'h1C, mk('h55,0,0,0,0,0,0,0,0), "R10 write wins");
    chk(next_desc === 1, "R10 pointer steps", 32'(next_desc), 32'd1);

    // R10 different descriptors, same cycle
    @(negedge clk);
    host_wr_en = 1; host_wr_addr = 8'h10; host_wr_be = 4'hF; host_wr_data = 32'h7;
    set_dma(2, 1,0,0,0,0,0, 1);
    @(negedge clk);
    host_wr_en = 0;
    irq_chk(1, 0, "R10 irq split");
    rd(8'h10, mk(7,0,0,0,0,0,0,0,0), "R10 split write");
    rd(8'h18, mk('h10,1,0,1,0,0,0,0,1), "R10 split completion");
    chk(next_desc === 2, "R9 R10 pointer", 32'(next_desc), 32'd2);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule